// File: doc/BRIEF.md
# Output-Compare Timer with Counter-Write Match Suppression

This block is a synchronous up-counter with two compare channels and an overflow detector. It shares one system clock with the rest of the chip. A one-cycle enable pulse, `tick_en`, stands in for the timer clock: the counter moves only on cycles where that pulse is high. The counter is 8 or 16 bits wide, chosen by `wide_mode`. On each enabled tick the present count is compared against compare registers A and B. An equal value raises that channel's flag. When the count passes from its top value back to zero, the overflow flag is raised.

Software reaches the counter, the compare registers, the flags and the interrupt enables through a small byte-wide register port. Reads are combinational. Any write to the counter's low byte hides compare matches on the next enabled tick, however long the timer is stopped before that tick comes. Because of this, a compare register can be loaded with the same value as the counter without raising a false flag when counting resumes. Each flag drives a level interrupt request through its enable bit. A flag is cleared by writing a one to it or by a per-channel acknowledge pulse.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter, both compare registers, the high-byte holding register, the flags and the enables are all zero, and every interrupt output is low.
- R2: The counter advances by one only on cycles with `tick_en` high. On other cycles it keeps its value, unless software writes it.
- R3: With `wide_mode`=0 the count wraps from 0xFF to 0x00, and the wrapping tick sets the overflow flag (flag bit 2). With `wide_mode`=1 the wrap is from 0xFFFF to 0x0000, and passing 0x00FF to 0x0100 sets no flag.
- R4: On an enabled tick where the present count equals compare register A (flag bit 0) or B (flag bit 1), that flag reads one from the next cycle on. The comparison uses the low 8 bits in narrow mode and all 16 bits in wide mode.
- R5: Writing address 0 loads the counter with {holding byte, data}. That write disables compare matches on the next enabled tick only, even if `tick_en` stays low for many cycles in between. A counter write on a tick cycle takes priority over the increment.
- R6: If the value written to the counter equals a compare register, the match on that value is lost. The same compare value is flagged normally when the count reaches it again later.
- R7: Writing address 6 clears each flag whose data bit is one. Zero bits leave their flags unchanged. A hardware set in the same cycle as a clear leaves the flag set.
- R8: A pulse on `ack_a` or `ack_b` clears flag A or flag B, respectively.
- R9: `irq_a`, `irq_b` and `irq_ovf` equal flag bits 0, 1 and 2, each ANDed with the matching enable bit written at address 7.
- R10: Register map, read and write: 0 counter low byte; 1 counter high byte (a write goes to the holding register, a read returns the live high byte); 2 and 3 compare A low and high; 4 and 5 compare B low and high; 6 flags {ovf,B,A}; 7 enables {ovf,B,A}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle timer clock enable |
| wide_mode | input | 1 | 1 selects 16-bit counting and compare |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| ack_a | input | 1 | Interrupt acknowledge, channel A |
| ack_b | input | 1 | Interrupt acknowledge, channel B |
| irq_a | output | 1 | Compare A interrupt request |
| irq_b | output | 1 | Compare B interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The bench writes the counter to exactly the compare value and then idles the timer for several cycles before the next tick. A design that dropped the suppression at the first idle cycle would raise flag A there. The bench then checks that the very next match on B does fire, which catches a design that suppressed matches for too long. A flag clear is issued on the same cycle as a matching tick, so a design where the clear wins would read zero. In wide mode the bench checks that commits of the high byte are deferred, that the wrap is at 0xFFFF, and that crossing 0x00FF raises no overflow, which a narrow-only compare or wrap would get wrong.

// File: rtl/cmp_timer.sv
module cmp_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wide_mode,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       ack_a,
  input  logic       ack_b,
  output logic       irq_a,
  output logic       irq_b,
  output logic       irq_ovf
);
  logic [15:0] cnt, cmp_a, cmp_b;
  logic [7:0]  hi_hold;
  logic [2:0]  flags, ien;
  logic        blk;

  wire wr_cnt = wr_en && (wr_addr == 3'd0);
  wire run    = tick_en && !wr_cnt;
  wire live   = run && !blk;
  wire at_max = wide_mode ? (cnt == 16'hFFFF) : (cnt[7:0] == 8'hFF);
  wire eq_a   = wide_mode ? (cnt == cmp_a) : (cnt[7:0] == cmp_a[7:0]);
  wire eq_b   = wide_mode ? (cnt == cmp_b) : (cnt[7:0] == cmp_b[7:0]);

  wire [2:0] set_v = {run && at_max, live && eq_b, live && eq_a};
  wire [2:0] clr_v = ((wr_en && wr_addr == 3'd6) ? wr_data[2:0] : 3'b000)
                   | {1'b0, ack_b, ack_a};

  logic [15:0] cnt_nxt;
  always_comb begin
    if (wr_cnt)          cnt_nxt = {hi_hold, wr_data};
    else if (!tick_en)   cnt_nxt = cnt;
    else if (at_max)     cnt_nxt = 16'h0000;
    else if (wide_mode)  cnt_nxt = cnt + 16'd1;
    else                 cnt_nxt = {8'h00, cnt[7:0] + 8'd1};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      cmp_a   <= '0;
      cmp_b   <= '0;
      hi_hold <= '0;
      flags   <= '0;
      ien     <= '0;
      blk     <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      flags <= set_v | (flags & ~clr_v);
      if (wr_cnt)       blk <= 1'b1;
      else if (tick_en) blk <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          3'd1: hi_hold     <= wr_data;
          3'd2: cmp_a[7:0]  <= wr_data;
          3'd3: cmp_a[15:8] <= wr_data;
          3'd4: cmp_b[7:0]  <= wr_data;
          3'd5: cmp_b[15:8] <= wr_data;
          3'd7: ien         <= wr_data[2:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0: rd_data = cnt[7:0];
      3'd1: rd_data = cnt[15:8];
      3'd2: rd_data = cmp_a[7:0];
      3'd3: rd_data = cmp_a[15:8];
      3'd4: rd_data = cmp_b[7:0];
      3'd5: rd_data = cmp_b[15:8];
      3'd6: rd_data = {5'b0, flags};
      default: rd_data = {5'b0, ien};
    endcase
  end

  assign irq_a   = flags[0] & ien[0];
  assign irq_b   = flags[1] & ien[1];
  assign irq_ovf = flags[2] & ien[2];
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        wide_mode,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic        ack_a,
  input logic [15:0] cnt,
  input logic [2:0]  flags
);
  wire wrc = wr_en && (wr_addr == 3'd0);
  logic pend;
  always_ff @(posedge clk) begin
    if (!rst_n)       pend <= 1'b0;
    else if (wrc)     pend <= 1'b1;
    else if (tick_en) pend <= 1'b0;
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !wrc |=> $stable(cnt));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !wrc && !wide_mode && cnt[7:0] != 8'hFF |=> cnt[7:0] == $past(cnt[7:0]) + 8'd1);
  // R3
  narrow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !wrc && !wide_mode && cnt[7:0] == 8'hFF |=> cnt[7:0] == 8'h00 && flags[2]);
  // R5
  blocked_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && tick_en && !wrc |=> !$rose(flags[0]) && !$rose(flags[1]));
  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_a && !tick_en |=> !flags[0]);
endmodule

bind cmp_timer cmp_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wide_mode(wide_mode),
  .wr_en(wr_en), .wr_addr(wr_addr), .ack_a(ack_a), .cnt(cnt), .flags(flags)
);

// File: tb/cmp_timer_tb.sv
`timescale 1ns/100ps
module cmp_timer_tb;
  logic clk = 0, rst_n = 0, tick_en = 0, wide_mode = 0, wr_en = 0, ack_a = 0, ack_b = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic irq_a, irq_b, irq_ovf;
  int n_chk = 0, n_bad = 0, pending = 0, cycles = 0;
  logic busy = 0;

  typedef struct { logic [3:0] addr; logic [7:0] exp; string tag; } item_t;
  item_t q[$];

  cmp_timer u_dut (.*);

  always #4 clk = ~clk;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      busy = 1;
      it = q.pop_front();
      if (it.addr == 4'd8) act = {5'b0, irq_ovf, irq_b, irq_a};
      else begin rd_addr = it.addr[2:0]; #0.5; act = rd_data; end
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, act, it.exp);
      end
      pending--;
      busy = 0;
    end
  end

  task automatic expect_v(input logic [3:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    pending++;
    q.push_back(it);
  endtask

  task automatic settle();
    wait (pending == 0 && !busy);
  endtask

  task automatic step(input logic t);
    tick_en = t;
    @(posedge clk); #1;
    tick_en = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic t);
    wr_en = 1; wr_addr = a; wr_data = d; tick_en = t;
    @(posedge clk); #1;
    wr_en = 0; tick_en = 0;
  endtask

  initial begin
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1;
    for (int a = 0; a < 8; a++) expect_v(a[3:0], 8'h00, "R1 reset reg");
    expect_v(4'd8, 8'h00, "R1 reset irq");
    settle();

    wr(3'd7, 8'h07, 0);
    wr(3'd2, 8'h05, 0);
    wr(3'd4, 8'h08, 0);
    expect_v(4'd2, 8'h05, "R10 cmpA lo");
    expect_v(4'd4, 8'h08, "R10 cmpB lo");
    expect_v(4'd7, 8'h07, "R10 enables");
    settle();

    ticks(3);
    step(0); step(0);
    expect_v(4'd0, 8'h03, "R2 count/hold");
    settle();

    ticks(3);
    expect_v(4'd0, 8'h06, "R4 count");
    expect_v(4'd6, 8'h01, "R4 flag A");
    expect_v(4'd8, 8'h01, "R9 irq A");
    settle();

    wr(3'd6, 8'h00, 0);
    expect_v(4'd6, 8'h01, "R7 zero no effect");
    settle();
    wr(3'd6, 8'h01, 0);
    expect_v(4'd6, 8'h00, "R7 w1c");
    settle();

    wr(3'd7, 8'h01, 0);
    ticks(3);
    expect_v(4'd6, 8'h02, "R4 flag B");
    expect_v(4'd8, 8'h00, "R9 irq gated");
    settle();
    ack_b = 1; @(posedge clk); #1; ack_b = 0;
    expect_v(4'd6, 8'h00, "R8 ack B");
    settle();
    wr(3'd7, 8'h07, 0);

    wr(3'd0, 8'h05, 0);
    step(0); step(0); step(0);
    step(1);
    expect_v(4'd0, 8'h06, "R5 count after load");
    expect_v(4'd6, 8'h00, "R6 equal write missed");
    settle();
    ticks(3);
    expect_v(4'd6, 8'h02, "R5 block one tick only");
    settle();
    wr(3'd6, 8'h02, 0);

    ticks(246);
    expect_v(4'd0, 8'hFF, "R3 at max");
    expect_v(4'd6, 8'h00, "R3 no early flag");
    settle();
    step(1);
    expect_v(4'd0, 8'h00, "R3 wrap");
    expect_v(4'd6, 8'h04, "R3 ovf flag");
    expect_v(4'd8, 8'h04, "R9 irq ovf");
    settle();
    wr(3'd6, 8'h04, 0);

    ticks(6);
    expect_v(4'd6, 8'h01, "R6 later match");
    settle();
    wr(3'd6, 8'h01, 0);

    wr(3'd0, 8'h07, 0);
    step(1);
    wr(3'd6, 8'h02, 1);
    expect_v(4'd6, 8'h02, "R7 set wins");
    settle();
    wr(3'd6, 8'h02, 0);

    wr(3'd0, 8'h20, 1);
    expect_v(4'd0, 8'h20, "R5 write beats tick");
    settle();

    wide_mode = 1;
    wr(3'd3, 8'h01, 0);
    wr(3'd2, 8'h02, 0);
    wr(3'd1, 8'h01, 0);
    expect_v(4'd1, 8'h00, "R10 hi held");
    expect_v(4'd0, 8'h20, "R10 lo unchanged");
    settle();
    wr(3'd0, 8'h00, 0);
    expect_v(4'd1, 8'h01, "R10 hi commit");
    settle();
    ticks(3);
    expect_v(4'd6, 8'h01, "R4 wide match A");
    settle();
    wr(3'd6, 8'h01, 0);

    wr(3'd1, 8'h00, 0);
    wr(3'd0, 8'hFE, 0);
    ticks(2);
    expect_v(4'd1, 8'h01, "R3 wide carry");
    expect_v(4'd6, 8'h00, "R3 wide no ovf at FF");
    settle();

    wr(3'd1, 8'hFF, 0);
    wr(3'd0, 8'hFE, 0);
    ticks(2);
    expect_v(4'd1, 8'h00, "R3 wide wrap hi");
    expect_v(4'd0, 8'h00, "R3 wide wrap lo");
    expect_v(4'd6, 8'h04, "R3 wide ovf");
    settle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule